// File: doc/BRIEF.md
# Standard-Definition Raster Timing Generator

This block produces the raster timing for standard-definition composite video. It derives a pixel strobe from the core clock, runs a pixel counter and a line counter, and decodes from them the horizontal sync, vertical sync, active-video enable and field flag. Downstream video logic uses it to know when to fetch pixels and where the sync intervals fall. Building the analog sync waveform, burst insertion and the DAC all happen elsewhere.

Two line standards are supported. `mode_sel` = 0 selects the 525-line standard and 1 selects the 625-line standard. `prog_en` = 1 selects progressive scan, where every field is a complete frame of fixed length. `prog_en` = 0 selects interlaced scan, where a short field and a long field alternate. Both inputs are plain control levels. They are sampled only at a frame boundary, so a change never tears a frame. All outputs are levels that hold steady between pixel strobes. There is no back-pressure, because the raster runs freely.

Every timing figure is a parameter. The defaults are the broadcast values: a 720-pixel active line, 14/64/60 front porch/sync/back porch for 525 lines and 20/64/60 for 625 lines, and a divide-by-8 strobe from a 108 MHz core clock, which gives 13.5 MHz.

Top module: `sdtv_raster_gen`

## Requirements
- R1: `pix_stb` is high for one core clock in every `PIX_DIV` clocks (default 8). The first strobe comes `PIX_DIV` clocks after reset is released. `pix_x`, `line_y` and `field` change only on a clock edge where `pix_stb` is high.
- R2: `pix_x` counts from 0 to HT-1 and then returns to 0, at which point `line_y` advances. HT is 858 when `mode_sel`=0 and 864 when `mode_sel`=1 (defaults).
- R3: `hsync` is high exactly when `pix_x` lies in [720+FP, 720+FP+64), where FP is 14 for 525 lines and 20 for 625 lines (defaults).
- R4: In progressive scan, a field (which is also the frame) has 262 lines for 525 and 312 lines for 625 (defaults), and `field` stays 0.
- R5: `vsync` is high for whole lines only. It covers exactly 3 lines, starting after the active lines plus the front-porch lines of the field. Active lines per field are 240 (525) or 288 (625), and front-porch lines are 3 (525) or 2 (625) (defaults).
- R6: `de` is high exactly when `pix_x` < 720 and `line_y` < the active line count of the field.
- R7: In interlaced scan, the first field (`field`=0) has the progressive line count and the second field (`field`=1) has one line more: 263 or 313. `field` changes only at the start of a field, where `pix_x`=0 and `line_y`=0.
- R8: `mode_sel` and `prog_en` take effect only at a frame start. In interlaced scan that is after the second field; in progressive scan it is after each field. Changes at any other time have no effect on the outputs until then.
- R9: Synchronous active-low reset sets `pix_x`, `line_y` and `field` to 0, restarts the strobe divider, and loads `mode_sel` and `prog_en` immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | 0 = 525-line, 1 = 625-line standard |
| prog_en | input | 1 | 1 = progressive scan, 0 = interlaced |
| pix_stb | output | 1 | One-clock pixel strobe |
| pix_x | output | CNT_W | Pixel position in the line |
| line_y | output | CNT_W | Line position in the field |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-video enable |
| field | output | 1 | 0 = first field, 1 = second field |

## Verification
The hardest case to reach is a configuration change that arrives in the middle of a frame, and above all in the middle of the first interlaced field. In that case the new standard must wait through a complete second field before it applies. The bench uses scaled-down timing parameters so that whole frames pass in a few thousand clocks. It flips `prog_en` and `mode_sel` at points away from frame boundaries, including during a first field. A behavioural model that latches the inputs only at its own frame ends then catches any premature switch on the very next pixel. A reset applied in the middle of the run, with a changed configuration, confirms that the new inputs are loaded at once.

// File: rtl/sdtv_raster_pkg.sv
package sdtv_raster_pkg;
  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } line_std_e;

  typedef struct packed {
    line_std_e std;
    logic      prog;
  } scan_cfg_t;
endpackage

// File: rtl/sdtv_pix_prescale.sv
module sdtv_pix_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb
);
  generate
    if (DIV <= 1) begin : g_pass
      assign stb = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + PW'(1);
      end
      assign stb = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/sdtv_raster_cnt.sv
module sdtv_raster_cnt
  import sdtv_raster_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int HTOT_A = 858,
  parameter int HTOT_B = 864,
  parameter int VTOT_A = 262,
  parameter int VTOT_B = 312
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             mode_sel,
  input  logic             prog_en,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] line_y,
  output logic             field,
  output scan_cfg_t        cfg
);
  localparam logic [CNT_W-1:0] HLAST_A = CNT_W'(HTOT_A - 1);
  localparam logic [CNT_W-1:0] HLAST_B = CNT_W'(HTOT_B - 1);
  localparam logic [CNT_W-1:0] VLAST_A = CNT_W'(VTOT_A - 1);
  localparam logic [CNT_W-1:0] VLAST_B = CNT_W'(VTOT_B - 1);

  logic [CNT_W-1:0] h_last, v_last;
  logic             long_field, end_px, end_ln, end_frame;
  scan_cfg_t        next_cfg;

  always_comb begin
    h_last     = (cfg.std == STD_625) ? HLAST_B : HLAST_A;
    long_field = !cfg.prog && field;
    v_last     = ((cfg.std == STD_625) ? VLAST_B : VLAST_A) + CNT_W'(long_field);
    end_px     = (pix_x == h_last);
    end_ln     = (line_y == v_last);
    end_frame  = cfg.prog || field;
    next_cfg   = '{std: line_std_e'(mode_sel), prog: prog_en};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_x  <= '0;
      line_y <= '0;
      field  <= 1'b0;
      cfg    <= next_cfg;
    end else if (stb) begin
      if (end_px) begin
        pix_x <= '0;
        if (end_ln) begin
          line_y <= '0;
          if (end_frame) begin
            field <= 1'b0;
            cfg   <= next_cfg;
          end else begin
            field <= 1'b1;
          end
        end else begin
          line_y <= line_y + CNT_W'(1);
        end
      end else begin
        pix_x <= pix_x + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdtv_raster_dec.sv
module sdtv_raster_dec
  import sdtv_raster_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int ACT_W   = 720,
  parameter int HFP_A   = 14,
  parameter int HFP_B   = 20,
  parameter int HSYNC_W = 64,
  parameter int VACT_A  = 240,
  parameter int VACT_B  = 288,
  parameter int VFP_A   = 3,
  parameter int VFP_B   = 2,
  parameter int VSYNC_L = 3
) (
  input  scan_cfg_t        cfg,
  input  logic [CNT_W-1:0] pix_x,
  input  logic [CNT_W-1:0] line_y,
  output logic             hsync,
  output logic             vsync,
  output logic             de
);
  localparam logic [CNT_W-1:0] HACT  = CNT_W'(ACT_W);
  localparam logic [CNT_W-1:0] HS0_A = CNT_W'(ACT_W + HFP_A);
  localparam logic [CNT_W-1:0] HS0_B = CNT_W'(ACT_W + HFP_B);
  localparam logic [CNT_W-1:0] HS1_A = CNT_W'(ACT_W + HFP_A + HSYNC_W);
  localparam logic [CNT_W-1:0] HS1_B = CNT_W'(ACT_W + HFP_B + HSYNC_W);
  localparam logic [CNT_W-1:0] VA_A  = CNT_W'(VACT_A);
  localparam logic [CNT_W-1:0] VA_B  = CNT_W'(VACT_B);
  localparam logic [CNT_W-1:0] VS0_A = CNT_W'(VACT_A + VFP_A);
  localparam logic [CNT_W-1:0] VS0_B = CNT_W'(VACT_B + VFP_B);
  localparam logic [CNT_W-1:0] VS1_A = CNT_W'(VACT_A + VFP_A + VSYNC_L);
  localparam logic [CNT_W-1:0] VS1_B = CNT_W'(VACT_B + VFP_B + VSYNC_L);

  logic             is_b;
  logic [CNT_W-1:0] hs0, hs1, va, vs0, vs1;

  always_comb begin
    is_b  = (cfg.std == STD_625);
    hs0   = is_b ? HS0_B : HS0_A;
    hs1   = is_b ? HS1_B : HS1_A;
    va    = is_b ? VA_B  : VA_A;
    vs0   = is_b ? VS0_B : VS0_A;
    vs1   = is_b ? VS1_B : VS1_A;
    hsync = (pix_x >= hs0) && (pix_x < hs1);
    vsync = (line_y >= vs0) && (line_y < vs1);
    de    = (pix_x < HACT) && (line_y < va);
  end
endmodule

// File: rtl/sdtv_raster_gen.sv
module sdtv_raster_gen
  import sdtv_raster_pkg::*;
#(
  parameter int PIX_DIV = 8,
  parameter int ACT_W   = 720,
  parameter int HFP_A   = 14,
  parameter int HFP_B   = 20,
  parameter int HSYNC_W = 64,
  parameter int HBP_A   = 60,
  parameter int HBP_B   = 60,
  parameter int VACT_A  = 240,
  parameter int VACT_B  = 288,
  parameter int VFP_A   = 3,
  parameter int VFP_B   = 2,
  parameter int VSYNC_L = 3,
  parameter int VTOT_A  = 262,
  parameter int VTOT_B  = 312,
  localparam int HTOT_A = ACT_W + HFP_A + HSYNC_W + HBP_A,
  localparam int HTOT_B = ACT_W + HFP_B + HSYNC_W + HBP_B,
  localparam int HMAX   = (HTOT_A > HTOT_B) ? HTOT_A : HTOT_B,
  localparam int VMAX   = ((VTOT_A > VTOT_B) ? VTOT_A : VTOT_B) + 1,
  localparam int CNT_W  = $clog2(((HMAX > VMAX) ? HMAX : VMAX) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             prog_en,
  output logic             pix_stb,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] line_y,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             field
);
  scan_cfg_t cfg;

  sdtv_pix_prescale #(.DIV(PIX_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .stb(pix_stb)
  );

  sdtv_raster_cnt #(
    .CNT_W(CNT_W), .HTOT_A(HTOT_A), .HTOT_B(HTOT_B),
    .VTOT_A(VTOT_A), .VTOT_B(VTOT_B)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .stb(pix_stb),
    .mode_sel(mode_sel), .prog_en(prog_en),
    .pix_x(pix_x), .line_y(line_y), .field(field), .cfg(cfg)
  );

  sdtv_raster_dec #(
    .CNT_W(CNT_W), .ACT_W(ACT_W), .HFP_A(HFP_A), .HFP_B(HFP_B),
    .HSYNC_W(HSYNC_W), .VACT_A(VACT_A), .VACT_B(VACT_B),
    .VFP_A(VFP_A), .VFP_B(VFP_B), .VSYNC_L(VSYNC_L)
  ) u_dec (
    .cfg(cfg), .pix_x(pix_x), .line_y(line_y),
    .hsync(hsync), .vsync(vsync), .de(de)
  );
endmodule

// File: rtl/sdtv_raster_chk.sv
module sdtv_raster_chk #(
  parameter int CNT_W = 10,
  parameter int ACT_W = 720
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_stb,
  input logic [CNT_W-1:0] pix_x,
  input logic [CNT_W-1:0] line_y,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic             field
);
  localparam logic [CNT_W-1:0] HACT = CNT_W'(ACT_W);

  a_r1_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |=> ($stable(pix_x) && $stable(line_y) && $stable(field)));

  a_r2_pixel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_stb && pix_x < HACT) |=> (pix_x == $past(pix_x) + CNT_W'(1)));

  a_r3_hsync_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> !de);

  a_r5_vsync_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> !de);

  a_r5_vsync_whole_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x != '0) |-> $stable(vsync));

  a_r6_de_in_active_pixels: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pix_x < HACT));

  a_r7_field_changes_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_x == '0 && line_y == '0) |-> $stable(field));
endmodule

bind sdtv_raster_gen sdtv_raster_chk #(.CNT_W(CNT_W), .ACT_W(ACT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .pix_x(pix_x),
  .line_y(line_y), .hsync(hsync), .vsync(vsync), .de(de), .field(field)
);

// File: tb/tb_sdtv_raster_gen.sv
module tb_sdtv_raster_gen;
  localparam int DIV = 2;
  localparam int AW = 16, HFA = 2, HFB = 3, HSW = 4, HBA = 3, HBB = 3;
  localparam int VAA = 10, VAB = 12, VFA = 3, VFB = 2, VSL = 3, VTA = 20, VTB = 22;
  localparam int HTA = AW + HFA + HSW + HBA;
  localparam int HTB = AW + HFB + HSW + HBB;
  localparam int CW = $clog2(((HTA > HTB) ? HTA : HTB) + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic prog_en = 1'b1;
  logic pix_stb, hsync, vsync, de, field;
  logic [CW-1:0] pix_x, line_y;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdtv_raster_gen #(
    .PIX_DIV(DIV), .ACT_W(AW), .HFP_A(HFA), .HFP_B(HFB), .HSYNC_W(HSW),
    .HBP_A(HBA), .HBP_B(HBB), .VACT_A(VAA), .VACT_B(VAB), .VFP_A(VFA),
    .VFP_B(VFB), .VSYNC_L(VSL), .VTOT_A(VTA), .VTOT_B(VTB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .prog_en(prog_en),
    .pix_stb(pix_stb), .pix_x(pix_x), .line_y(line_y), .hsync(hsync),
    .vsync(vsync), .de(de), .field(field)
  );

  // behavioural reference state
  int m_dv = 0, m_px = 0, m_ln = 0, m_fd = 0, m_std = 0, m_prog = 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dv = 0; m_px = 0; m_ln = 0; m_fd = 0;
      m_std = int'(mode_sel); m_prog = int'(prog_en);
    end else if (m_dv == DIV - 1) begin
      int ht, fl;
      m_dv = 0;
      ht = m_std ? HTB : HTA;
      if (m_px == ht - 1) begin
        m_px = 0;
        fl = (m_std ? VTB : VTA) + ((m_prog == 0 && m_fd == 1) ? 1 : 0);
        if (m_ln == fl - 1) begin
          m_ln = 0;
          if (m_prog == 1 || m_fd == 1) begin
            m_fd = 0; m_std = int'(mode_sel); m_prog = int'(prog_en);
          end else begin
            m_fd = 1;
          end
        end else m_ln++;
      end else m_px++;
    end else m_dv++;
  end

  always @(negedge clk) begin
    if (!done) begin
      int hf, va, vf;
      bit e_hs, e_vs, e_de;
      hf = m_std ? HFB : HFA;
      va = m_std ? VAB : VAA;
      vf = m_std ? VFB : VFA;
      e_hs = (m_px >= AW + hf) && (m_px < AW + hf + HSW);
      e_vs = (m_ln >= va + vf) && (m_ln < va + vf + VSL);
      e_de = (m_px < AW) && (m_ln < va);
      check(pix_stb == (m_dv == DIV - 1), "R1 strobe", int'(pix_stb), int'(m_dv == DIV - 1));
      check(int'(pix_x) == m_px, "R2 R8 pix_x", int'(pix_x), m_px);
      check(int'(line_y) == m_ln, "R4 R7 R8 line_y", int'(line_y), m_ln);
      check(hsync == e_hs, "R3 hsync", int'(hsync), int'(e_hs));
      check(vsync == e_vs, "R5 vsync", int'(vsync), int'(e_vs));
      check(de == e_de, "R6 de", int'(de), int'(e_de));
      check(int'(field) == m_fd, "R4 R7 field", int'(field), m_fd);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state seen at the ports
    check(pix_x == '0 && line_y == '0 && field == 1'b0, "R9 reset counters", int'(pix_x), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    prog_en = 1'b0;            // R8: mid-frame request for interlace
    repeat (2000) @(negedge clk);
    mode_sel = 1'b1;           // R8: request 625 during an interlaced frame
    repeat (6000) @(negedge clk);
    prog_en = 1'b1;            // R4: 625 progressive next
    repeat (3000) @(negedge clk);
    mode_sel = 1'b0;
    prog_en = 1'b0;
    rst_n = 1'b0;              // R9: reset loads new config at once
    repeat (3) @(negedge clk);
    check(pix_x == '0 && line_y == '0 && field == 1'b0, "R9 reset mid-run", int'(line_y), 0);
    rst_n = 1'b1;
    repeat (DIV - 1) @(negedge clk);
    check(pix_stb == 1'b1, "R1 first strobe", int'(pix_stb), 1);
    repeat (4500) @(negedge clk);
    finish_run();
  end
endmodule